// File: doc/BRIEF.md
# Global-History Correlating Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It is indexed two ways. A row is picked from a slice of the branch address. A shift register holding the outcomes of the most recent resolved branches then picks one of several saturating counters inside that row. The same address pattern can therefore get different predictions depending on the path that led to it. The predictor has `HIST_W` history bits, `CTR_W` counter bits and `2^IDX_W` rows. With no history bits it becomes a plain per-address counter table.

The fetch stage drives a branch address on the predict port and reads back a taken/not-taken guess. The guess is either combinational or registered by one cycle, chosen by a parameter. When the branch resolves, the back end presents the same address and the real outcome on the update port. That trains exactly one counter and shifts the outcome into the history. Counters have no address tag, so addresses that map to the same row share counters.

Top module: `corr_bpred`

## Requirements
- R1: After reset every counter holds the weak not-taken value `2^(CTR_W-1)-1` (01 for two-bit counters) and the history register is zero. Every address therefore predicts not-taken.
- R2: A counter steps up by one on a taken update and down by one on a not-taken update. The prediction is the counter's most significant bit. For two bits the encoding is 00 strong not-taken, 01 weak not-taken, 10 weak taken, 11 strong taken, so one taken update from reset flips that counter to predict taken.
- R3: Counters saturate at zero and at all-ones. With two-bit counters, a counter in a strong state needs two consecutive opposite outcomes before its prediction changes.
- R4: The row is `pc[PC_LSB +: IDX_W]`. No tag is kept, so two addresses that differ only outside that field share every counter.
- R5: Each valid update shifts the history left by one and places the resolved outcome in bit 0, on the same clock edge as the counter write. The history value forms the upper bits of the counter index, `{history, row}`, so it selects which counter of the row is used.
- R6: A valid update changes only the counter at the current history and the update row. When `upd_valid_i` is low, no counter and no history bit changes, whatever the other update inputs are.
- R7: The prediction reads the counter at the current history and the predict row. If an update lands in the same cycle, the prediction reflects the state before that update.
- R8: With `REG_PRED` set, `pred_taken_o` is the value the combinational prediction had in the previous cycle, taken before that edge's update.
- R9: With `HIST_W = 0` and `CTR_W = 2`, the block behaves as a per-row two-bit counter table that ignores branch history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pred_pc_i | input | PC_W | Address of the branch being predicted |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| upd_valid_i | input | 1 | A resolved branch is being reported |
| upd_pc_i | input | PC_W | Address of the resolved branch |
| upd_taken_i | input | 1 | Resolved direction, 1 = taken |

## Verification
A counter or history bit holding a wrong value does not show at the ports until the bench predicts the affected row while the history points at the faulty counter. A history register that shifted the wrong way, or shifted on an invalid update, therefore shows up one or two branches later as a wrong guess on a row it never touched directly. The bench keeps the history walking through known values and probes the trained rows after every update, so a stray write or a wrong shift is exposed within a few cycles. The directed cases pin down the literal predictions. The random phase compares every probe against a model of the counter and history behaviour.

// File: rtl/bp_pkg.sv
package bp_pkg;
  function automatic int unsigned ctr_max(int unsigned w);
    return (1 << w) - 1;
  endfunction

  // weak not-taken: one below the taken threshold
  function automatic int unsigned ctr_weak_nt(int unsigned w);
    return (1 << (w - 1)) - 1;
  endfunction
endpackage

// File: rtl/bp_ctr_step.sv
module bp_ctr_step #(
  parameter int unsigned CTR_W = 2
) (
  input  logic [CTR_W-1:0] cur_i,
  input  logic             taken_i,
  output logic [CTR_W-1:0] nxt_o
);
  localparam logic [CTR_W-1:0] MAXV = CTR_W'(bp_pkg::ctr_max(CTR_W));
  localparam logic [CTR_W-1:0] ONE  = CTR_W'(1);

  always_comb begin
    nxt_o = cur_i;
    if (taken_i) begin
      if (cur_i != MAXV) nxt_o = cur_i + ONE;
    end else begin
      if (cur_i != '0) nxt_o = cur_i - ONE;
    end
  end
endmodule

// File: rtl/bp_ghr.sv
module bp_ghr #(
  parameter int unsigned HIST_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              shift_i,
  input  logic              bit_i,
  output logic [HIST_W-1:0] hist_o
);
  logic [HIST_W-1:0] hist_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      hist_q <= '0;
    else if (shift_i) hist_q <= (hist_q << 1) | HIST_W'(bit_i);
  end

  assign hist_o = hist_q;

  // R5
  ghr_shift_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    shift_i |=> hist_q[0] == $past(bit_i));

  // R6
  ghr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !shift_i |=> $stable(hist_q));
endmodule

// File: rtl/bp_ctr_table.sv
module bp_ctr_table #(
  parameter int unsigned TAB_W = 8,
  parameter int unsigned CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TAB_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [TAB_W-1:0] wr_idx_i,
  input  logic             wr_taken_i
);
  localparam int unsigned      ENTRIES = 1 << TAB_W;
  localparam logic [CTR_W-1:0] INITV   = CTR_W'(bp_pkg::ctr_weak_nt(CTR_W));
  localparam logic [CTR_W-1:0] MAXV    = CTR_W'(bp_pkg::ctr_max(CTR_W));

  logic [CTR_W-1:0] ctr_q [ENTRIES];
  logic [CTR_W-1:0] wr_cur;
  logic [CTR_W-1:0] wr_nxt;

  assign wr_cur     = ctr_q[wr_idx_i];
  assign rd_taken_o = ctr_q[rd_idx_i][CTR_W-1];

  bp_ctr_step #(.CTR_W(CTR_W)) u_step (
    .cur_i  (wr_cur),
    .taken_i(wr_taken_i),
    .nxt_o  (wr_nxt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < ENTRIES; i++) ctr_q[i] <= INITV;
    end else if (wr_en_i) begin
      ctr_q[wr_idx_i] <= wr_nxt;
    end
  end

  // last write, kept for the checks below
  logic             chk_v_q;
  logic             chk_t_q;
  logic [TAB_W-1:0] chk_idx_q;
  logic [CTR_W-1:0] chk_old_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chk_v_q   <= 1'b0;
      chk_t_q   <= 1'b0;
      chk_idx_q <= '0;
      chk_old_q <= '0;
    end else begin
      chk_v_q   <= wr_en_i;
      chk_t_q   <= wr_taken_i;
      chk_idx_q <= wr_idx_i;
      chk_old_q <= wr_cur;
    end
  end

  // R3
  sat_hi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_v_q && chk_t_q && chk_old_q == MAXV) |-> ctr_q[chk_idx_q] == MAXV);

  // R3
  sat_lo_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_v_q && !chk_t_q && chk_old_q == '0) |-> ctr_q[chk_idx_q] == '0);

  // R2
  step_up_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_v_q && chk_t_q && chk_old_q != MAXV) |-> ctr_q[chk_idx_q] == chk_old_q + CTR_W'(1));

  // R2
  step_dn_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_v_q && !chk_t_q && chk_old_q != '0) |-> ctr_q[chk_idx_q] == chk_old_q - CTR_W'(1));
endmodule

// File: rtl/corr_bpred.sv
module corr_bpred #(
  parameter int unsigned PC_W     = 32,
  parameter int unsigned PC_LSB   = 2,
  parameter int unsigned IDX_W    = 6,
  parameter int unsigned HIST_W   = 2,
  parameter int unsigned CTR_W    = 2,
  parameter bit          REG_PRED = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i
);
  localparam int unsigned TAB_W = IDX_W + HIST_W;

  logic [IDX_W-1:0] pred_row;
  logic [IDX_W-1:0] upd_row;
  logic [TAB_W-1:0] pred_idx;
  logic [TAB_W-1:0] upd_idx;
  logic             pred_raw;
  logic             unused_pc;

  assign pred_row  = pred_pc_i[PC_LSB +: IDX_W];
  assign upd_row   = upd_pc_i[PC_LSB +: IDX_W];
  assign unused_pc = ^{pred_pc_i, upd_pc_i};

  if (HIST_W > 0) begin : g_hist
    logic [HIST_W-1:0] ghr;

    bp_ghr #(.HIST_W(HIST_W)) u_ghr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .shift_i(upd_valid_i),
      .bit_i  (upd_taken_i),
      .hist_o (ghr)
    );

    assign pred_idx = {ghr, pred_row};
    assign upd_idx  = {ghr, upd_row};
  end else begin : g_nohist
    assign pred_idx = pred_row;
    assign upd_idx  = upd_row;
  end

  bp_ctr_table #(.TAB_W(TAB_W), .CTR_W(CTR_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .rd_idx_i  (pred_idx),
    .rd_taken_o(pred_raw),
    .wr_en_i   (upd_valid_i),
    .wr_idx_i  (upd_idx),
    .wr_taken_i(upd_taken_i)
  );

  if (REG_PRED) begin : g_reg
    logic taken_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) taken_q <= 1'b0;
      else         taken_q <= pred_raw;
    end
    assign pred_taken_o = taken_q;
  end else begin : g_comb
    assign pred_taken_o = pred_raw;
  end
endmodule

// File: tb/tb_corr_bpred.sv
`timescale 1ns/1ps
module tb_corr_bpred;
  localparam int PC_LSB = 2;
  localparam int IDX_W  = 6;
  localparam int ROWS   = 1 << IDX_W;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pred_pc = '0;
  logic [31:0] upd_pc = '0;
  logic        upd_valid = 1'b0;
  logic        upd_taken = 1'b0;
  logic        p_dut, p_reg, p_m0;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  int m2[4*ROWS];
  int m0[ROWS];
  int ghr;

  always #4 clk = ~clk;

  corr_bpred dut (
    .clk_i(clk), .rst_ni(rst_n), .pred_pc_i(pred_pc), .pred_taken_o(p_dut),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  corr_bpred #(.REG_PRED(1'b1)) dut_reg (
    .clk_i(clk), .rst_ni(rst_n), .pred_pc_i(pred_pc), .pred_taken_o(p_reg),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  corr_bpred #(.HIST_W(0)) dut_m0 (
    .clk_i(clk), .rst_ni(rst_n), .pred_pc_i(pred_pc), .pred_taken_o(p_m0),
    .upd_valid_i(upd_valid), .upd_pc_i(upd_pc), .upd_taken_i(upd_taken));

  function automatic int row_of(logic [31:0] pc);
    return int'(pc[PC_LSB +: IDX_W]);
  endfunction

  function automatic int sat(int v, bit t);
    if (t) return (v < 3) ? v + 1 : 3;
    return (v > 0) ? v - 1 : 0;
  endfunction

  function automatic bit exp2(logic [31:0] pc);
    return m2[ghr*ROWS + row_of(pc)] >= 2;
  endfunction

  function automatic bit exp0(logic [31:0] pc);
    return m0[row_of(pc)] >= 2;
  endfunction

  task automatic model_upd(logic [31:0] pc, bit t);
    int i = ghr*ROWS + row_of(pc);
    m2[i] = sat(m2[i], t);
    m0[row_of(pc)] = sat(m0[row_of(pc)], t);
    ghr = ((ghr << 1) | int'(t)) & 3;
  endtask

  task automatic chk(bit act, bit exp, string what);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", what, act, exp);
    end
  endtask

  task automatic apply_reset();
    @(negedge clk);
    rst_n = 1'b0;
    upd_valid = 1'b0;
    repeat (2) @(posedge clk);
    for (int i = 0; i < 4*ROWS; i++) m2[i] = 1;
    for (int i = 0; i < ROWS; i++) m0[i] = 1;
    ghr = 0;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic upd(logic [31:0] pc, bit t);
    @(negedge clk);
    upd_pc = pc; upd_taken = t; upd_valid = 1'b1;
    @(posedge clk);
    model_upd(pc, t);
    @(negedge clk);
    upd_valid = 1'b0;
  endtask

  // model comparison on all three instances
  task automatic probe(logic [31:0] pc, string req);
    bit e2, e0;
    @(negedge clk);
    pred_pc = pc;
    #1;
    e2 = exp2(pc);
    e0 = exp0(pc);
    chk(p_dut, e2, {req, " history table"});
    chk(p_m0, e0, "R9 history-free table");
    @(posedge clk);
    #1;
    chk(p_reg, e2, "R8 registered output");
  endtask

  // literal expectations worked out by hand
  task automatic probe_lit(logic [31:0] pc, bit l2, bit l0, string req);
    @(negedge clk);
    pred_pc = pc;
    #1;
    chk(p_dut, l2, {req, " default config"});
    chk(p_m0, l0, {req, " R9 no-history config"});
  endtask

  localparam logic [31:0] PC_A = 32'h0000_0014;  // row 5

  task automatic t_reset();
    apply_reset();
    probe_lit(32'h0, 1'b0, 1'b0, "R1 row 0");
    probe_lit(PC_A, 1'b0, 1'b0, "R1 row 5");
    probe_lit(32'hFFFF_FFFC, 1'b0, 1'b0, "R1 row 63");
    @(posedge clk); #1;
    chk(p_reg, 1'b0, "R1 registered after reset");
  endtask

  task automatic t_history();
    apply_reset();
    upd(PC_A, 1'b1);                      // h00: 01->10, ghr 01
    probe_lit(PC_A, 1'b0, 1'b1, "R5 history moved off trained counter / R2 weak flip");
    probe_lit(PC_A + 4, 1'b0, 1'b0, "R6 neighbour row untouched");
    upd(PC_A, 1'b0);                      // h01 -> 00, ghr 10
    upd(PC_A, 1'b0);                      // h10 -> 00, ghr 00
    probe_lit(PC_A, 1'b1, 1'b0, "R6 other counters of row kept");
    probe_lit(PC_A + 32'h100, 1'b1, 1'b0, "R4 alias shares counter");
    probe(PC_A, "R5");
  endtask

  task automatic t_hysteresis();
    apply_reset();
    upd(PC_A, 1'b1); upd(PC_A, 1'b1); upd(PC_A, 1'b1);
    probe_lit(PC_A, 1'b1, 1'b1, "R2 trained taken");
    upd(PC_A, 1'b0);
    probe_lit(PC_A, 1'b0, 1'b1, "R3 strong survives one miss");
    upd(PC_A, 1'b0);
    probe_lit(PC_A, 1'b1, 1'b0, "R3 second miss flips");
    upd(PC_A, 1'b0); upd(PC_A, 1'b0); upd(PC_A, 1'b1);
    probe(PC_A, "R3 saturate low");
    chk(p_m0, 1'b0, "R3 floor saturation");
  endtask

  task automatic t_ignore();
    apply_reset();
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      upd_pc = PC_A; upd_taken = 1'b1; upd_valid = 1'b0;
      @(posedge clk);
    end
    probe_lit(PC_A, 1'b0, 1'b0, "R6 invalid update ignored");
    upd(PC_A, 1'b1);
    probe_lit(PC_A, 1'b0, 1'b1, "R6 history not shifted by invalid update");
  endtask

  task automatic t_same_cycle();
    apply_reset();
    upd(PC_A, 1'b1); upd(PC_A, 1'b1); upd(PC_A, 1'b0); upd(PC_A, 1'b0);
    @(negedge clk);
    pred_pc = PC_A; upd_pc = PC_A; upd_taken = 1'b0; upd_valid = 1'b1;
    #1;
    chk(p_dut, 1'b1, "R7 pre-update value in update cycle");
    @(posedge clk);
    #1;
    model_upd(PC_A, 1'b0);
    chk(p_reg, 1'b1, "R8 registered captures pre-update value");
    chk(p_dut, 1'b0, "R7 value after update");
    @(negedge clk);
    upd_valid = 1'b0;
    @(posedge clk);
    #1;
    chk(p_reg, 1'b0, "R8 one cycle later");
  endtask

  task automatic t_random();
    apply_reset();
    for (int k = 0; k < 400; k++) begin
      logic [31:0] pc;
      bit v, t;
      pc = (32'($urandom_range(0, 3)) << PC_LSB) | (32'($urandom_range(0, 3)) << 8);
      v = bit'($urandom_range(0, 3) != 0);
      t = bit'($urandom_range(0, 1));
      if (v) upd(pc, t);
      probe((32'($urandom_range(0, 3)) << PC_LSB) | (32'($urandom_range(0, 3)) << 8),
            "R4 R5 R6 R7 random");
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_history();
    t_hysteresis();
    t_ignore();
    t_same_cycle();
    t_random();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule